// File: doc/BRIEF.md
# External Pin Interrupt Detector

This block watches a small group of external pins and turns selected conditions on them into interrupt requests, one request line per pin, for a downstream interrupt controller that does the arbitration. Each pin can be set to react to a low level, a rising edge, a falling edge or either edge. Edge events are caught in a sticky flag that software clears by writing a one to it. A pin that is configured as an output drives a software-written value and produces no request. Pin 0 is reserved and never requests.

Software reaches the block through a simple register port: a write strobe, an address, write data and a combinational read-data bus. Pin inputs are synchronized with two flip-flops before detection, and edges are found by comparing the current synchronized sample with the one before it. The reset is asynchronous active-low and is released synchronously inside the block.

Top module: `edge_port_irq`

## Requirements
- R1: After reset every software register reads zero, all requests are low, all output enables are low and the output data is zero.
- R2: The trigger field of pin n is bits [2n+1:2n] of the mode register (address 0); code 00 selects low level, 01 rising edge, 10 falling edge, 11 both edges, and the mode register reads back what was written.
- R3: In low-level mode the flag of an input pin equals the inverted synchronized pin level, so its request rises two clock edges after the pin falls and drops two edges after it rises; address 4 reads the synchronized pin levels.
- R4: In rising-edge mode a low-to-high transition sets the flag on the third clock edge after the pin change, falling transitions do nothing, and the flag stays set after the pin returns low.
- R5: In falling-edge mode a high-to-low transition sets the flag, and the flag stays set when the pin goes high again.
- R6: In both-edges mode either transition sets the flag.
- R7: Writing the flag register (address 5) clears each flag whose write-data bit is 1; bits written as 0 leave their flags unchanged.
- R8: When an edge is detected in the same cycle as a clear write for that pin, the flag ends up set.
- R9: A request is driven only when the enable bit of the pin (address 2) is 1; a latched flag with its enable at 0 remains readable and raises the request once the enable is set.
- R10: A pin whose direction bit (address 1) is 1 drives its output-enable high and the data-register bit (address 3) on its output, raises no request and latches no edge flag.
- R11: Pin 0 never raises a request and its flag always reads 0, in every trigger mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| pin_in | input | 8 | Raw external pin levels |
| pin_out | output | 8 | Output value for pins configured as outputs |
| pin_oe | output | 8 | Output enable per pin |
| irq_req | output | 8 | Interrupt request per pin, bit 0 always low |

## Verification
Each trigger mode is driven with both a rising and a falling transition on its pin, which separates the four codes from each other and shows whether the field sits at the right bit position. Pins are returned to their idle level after a flag is latched to tell sticky edge flags from level-following ones, and checks one cycle before the expected response pin down the synchronizer latency. A clear is timed to land on the very edge a transition is detected, which distinguishes edge-wins from clear-wins, and enable, direction and the reserved pin are exercised with real transitions so that gating is seen at the request outputs and in the flag readback.

// File: rtl/ep_pkg.sv
package ep_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_e;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EN    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DOUT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd5;

endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= 2'b00;
    end else begin
      chain_q <= {chain_q[0], 1'b1};
    end
  end

  assign rst_q_n = chain_q[1];

endmodule

// File: rtl/ep_sync.sv
module ep_sync #(
  parameter int          W      = 8,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= IDLE;
      end
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ep_pin_cell.sv
module ep_pin_cell
  import ep_pkg::*;
#(
  parameter bit USED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       is_out,
  input  logic       en,
  input  logic       smp,
  input  logic       smp_prev,
  input  logic       clr,
  output logic       flag,
  output logic       req
);

  trig_e trig;
  logic  edge_hit;
  logic  latch_q;
  logic  latch_d;
  logic  latch_ce;

  assign trig = trig_e'(mode);

  always_comb begin
    case (trig)
      TRIG_RISE: edge_hit = smp & ~smp_prev;
      TRIG_FALL: edge_hit = ~smp & smp_prev;
      TRIG_BOTH: edge_hit = smp ^ smp_prev;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (is_out || (trig == TRIG_LOW)) begin
      latch_d = 1'b0;
    end else if (edge_hit) begin
      latch_d = 1'b1;
    end else if (clr) begin
      latch_d = 1'b0;
    end else begin
      latch_d = latch_q;
    end
    latch_ce = (latch_d != latch_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (latch_ce) begin
      latch_q <= latch_d;
    end
  end

  logic flag_raw;

  assign flag_raw = (trig == TRIG_LOW) ? (~smp & ~is_out) : latch_q;
  assign flag     = USED ? flag_raw : 1'b0;
  assign req      = flag & en & ~is_out;

endmodule

// File: rtl/ep_regs.sv
module ep_regs
  import ep_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [2*NPINS-1:0] wdata,
  input  logic [NPINS-1:0]   level,
  input  logic [NPINS-1:0]   flags,
  output logic [2*NPINS-1:0] mode_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   en_q,
  output logic [NPINS-1:0]   dout_q,
  output logic [NPINS-1:0]   clr,
  output logic [2*NPINS-1:0] rdata
);

  localparam int MW  = 2 * NPINS;
  localparam int PAD = MW - NPINS;

  logic mode_ce, dir_ce, en_ce, dout_ce;

  always_comb begin
    mode_ce = wr && (addr == ADR_MODE);
    dir_ce  = wr && (addr == ADR_DIR);
    en_ce   = wr && (addr == ADR_EN);
    dout_ce = wr && (addr == ADR_DOUT);
    clr     = (wr && (addr == ADR_FLAG)) ? wdata[NPINS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_ce) begin
      mode_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_ce) begin
      dir_q <= wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_ce) begin
      dout_q <= wdata[NPINS-1:0];
    end
  end

  always_comb begin
    case (addr)
      ADR_MODE:  rdata = mode_q;
      ADR_DIR:   rdata = {{PAD{1'b0}}, dir_q};
      ADR_EN:    rdata = {{PAD{1'b0}}, en_q};
      ADR_DOUT:  rdata = {{PAD{1'b0}}, dout_q};
      ADR_LEVEL: rdata = {{PAD{1'b0}}, level};
      ADR_FLAG:  rdata = {{PAD{1'b0}}, flags};
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/edge_port_irq.sv
module edge_port_irq
  import ep_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [2*NPINS-1:0] reg_wdata,
  output logic [2*NPINS-1:0] reg_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   irq_req
);

  localparam int MW = 2 * NPINS;

  logic             rst_q_n;
  logic [NPINS-1:0] smp;
  logic [NPINS-1:0] smp_prev;
  logic [MW-1:0]    mode_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] dout_q;
  logic [NPINS-1:0] clr_vec;
  logic [NPINS-1:0] flag_vec;

  ep_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ep_sync #(
    .W      (NPINS),
    .STAGES (SYNC_STAGES),
    .IDLE   ({NPINS{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (pin_in),
    .q     (smp)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      smp_prev <= '1;
    end else begin
      smp_prev <= smp;
    end
  end

  ep_regs #(
    .NPINS (NPINS)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .level  (smp),
    .flags  (flag_vec),
    .mode_q (mode_q),
    .dir_q  (dir_q),
    .en_q   (en_q),
    .dout_q (dout_q),
    .clr    (clr_vec),
    .rdata  (reg_rdata)
  );

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    ep_pin_cell #(
      .USED (n != 0)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .mode     (mode_q[2*n+1:2*n]),
      .is_out   (dir_q[n]),
      .en       (en_q[n]),
      .smp      (smp[n]),
      .smp_prev (smp_prev[n]),
      .clr      (clr_vec[n]),
      .flag     (flag_vec[n]),
      .req      (irq_req[n])
    );
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/ep_checker.sv
module ep_checker
  import ep_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr,
  input logic [2:0]         addr,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   dir_q,
  input logic [NPINS-1:0]   en_q,
  input logic [NPINS-1:0]   smp,
  input logic [NPINS-1:0]   smp_prev,
  input logic [NPINS-1:0]   clr_vec,
  input logic [NPINS-1:0]   flag_vec,
  input logic [NPINS-1:0]   irq_req
);

  logic cfg_wr;
  assign cfg_wr = wr && ((addr == ADR_MODE) || (addr == ADR_DIR));

  AST_PIN0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req[0] && !flag_vec[0]); // R11

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en_q) == '0); // R9

  AST_OUTPUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & dir_q) == '0); // R10

  for (genvar n = 1; n < NPINS; n++) begin : g_chk
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*n+1:2*n] != 2'b00) && flag_vec[n] && !clr_vec[n] && !cfg_wr
      |=> flag_vec[n]); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*n+1:2*n] != 2'b00) && clr_vec[n] && (smp[n] == smp_prev[n]) && !cfg_wr
      |=> !flag_vec[n]); // R7

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*n+1:2*n] == 2'b01) && smp[n] && !smp_prev[n] && clr_vec[n]
      && !dir_q[n] && !cfg_wr
      |=> flag_vec[n]); // R8
  end

endmodule

bind edge_port_irq ep_checker #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .wr       (reg_wr),
  .addr     (reg_addr),
  .mode_q   (mode_q),
  .dir_q    (dir_q),
  .en_q     (en_q),
  .smp      (smp),
  .smp_prev (smp_prev),
  .clr_vec  (clr_vec),
  .flag_vec (flag_vec),
  .irq_req  (irq_req)
);

// File: tb/sim_edge_port_irq.sv
module sim_edge_port_irq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic [7:0]  irq_req;

  always #10 clk = ~clk;

  edge_port_irq u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_req   (irq_req)
  );

  localparam int SEL_REQ = 0;
  localparam int SEL_RD  = 1;
  localparam int SEL_OE  = 2;
  localparam int SEL_OUT = 3;

  typedef struct {
    string       tag;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      SEL_REQ: return {8'h00, irq_req};
      SEL_RD:  return reg_rdata;
      SEL_OE:  return {8'h00, pin_oe};
      default: return {8'h00, pin_out};
    endcase
  endfunction

  // Monitor: compares queued expectations a little after each falling edge
  item_t it;
  logic [15:0] got;
  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      it  = q.pop_front();
      got = observe(it.sel);
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_out(string tag, int sel, logic [15:0] v);
    q.push_back('{tag, sel, v});
    wait (q.size() == 0);
  endtask

  task automatic expect_reg(string tag, logic [2:0] a, logic [15:0] v);
    reg_addr = a;
    expect_out(tag, SEL_RD, v);
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic set_pin(int n, logic v);
    @(negedge clk);
    pin_in[n] = v;
  endtask

  task automatic ticks(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = 3'd0;
    reg_wdata = 16'h0000;
    pin_in    = 8'hFF;
    ticks(5);
    rst_n = 1'b1;
    ticks(4);

    // R1: reset state
    expect_out("R1 req", SEL_REQ, 16'h0000);
    expect_out("R1 oe", SEL_OE, 16'h0000);
    expect_out("R1 out", SEL_OUT, 16'h0000);
    expect_reg("R1 mode", 3'd0, 16'h0000);
    expect_reg("R1 dir", 3'd1, 16'h0000);
    expect_reg("R1 en", 3'd2, 16'h0000);
    expect_reg("R1 flag", 3'd5, 16'h0000);

    // R3: low-level mode on pin 1
    wr_reg(3'd2, 16'h0002);
    set_pin(1, 1'b0);
    ticks(1);
    expect_out("R3 latency", SEL_REQ, 16'h0000);
    ticks(1);
    expect_out("R3 low asserts", SEL_REQ, 16'h0002);
    expect_reg("R3 flag", 3'd5, 16'h0002);
    expect_reg("R3 level read", 3'd4, 16'h00FD);
    set_pin(1, 1'b1);
    ticks(2);
    expect_out("R3 high releases", SEL_REQ, 16'h0000);

    // R4: rising edge on pin 2
    wr_reg(3'd0, 16'h0010);
    wr_reg(3'd2, 16'h0004);
    set_pin(2, 1'b0);
    ticks(3);
    expect_out("R4 fall ignored", SEL_REQ, 16'h0000);
    set_pin(2, 1'b1);
    ticks(2);
    expect_out("R4 latency", SEL_REQ, 16'h0000);
    ticks(1);
    expect_out("R4 rise sets", SEL_REQ, 16'h0004);
    set_pin(2, 1'b0);
    ticks(3);
    expect_out("R4 sticky", SEL_REQ, 16'h0004);

    // R7: clear semantics
    wr_reg(3'd5, 16'h0000);
    expect_out("R7 zero no effect", SEL_REQ, 16'h0004);
    wr_reg(3'd5, 16'h00FB);
    expect_out("R7 other bits no effect", SEL_REQ, 16'h0004);
    wr_reg(3'd5, 16'h0004);
    expect_out("R7 one clears", SEL_REQ, 16'h0000);

    // R8: edge detected on the same edge as the clear
    set_pin(2, 1'b1);
    ticks(1);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 3'd5;
    reg_wdata = 16'h0004;
    @(negedge clk);
    reg_wr    = 1'b0;
    expect_out("R8 edge wins", SEL_REQ, 16'h0004);
    wr_reg(3'd5, 16'h0004);
    expect_out("R8 later clear", SEL_REQ, 16'h0000);

    // R5: falling edge on pin 3
    wr_reg(3'd0, 16'h0080);
    wr_reg(3'd2, 16'h0008);
    set_pin(3, 1'b0);
    ticks(3);
    expect_out("R5 fall sets", SEL_REQ, 16'h0008);
    set_pin(3, 1'b1);
    ticks(3);
    expect_out("R5 sticky", SEL_REQ, 16'h0008);
    expect_reg("R5 flag", 3'd5, 16'h0008);
    wr_reg(3'd5, 16'h0008);
    expect_out("R5 cleared", SEL_REQ, 16'h0000);

    // R6: both edges on pin 4
    wr_reg(3'd0, 16'h0300);
    wr_reg(3'd2, 16'h0010);
    set_pin(4, 1'b0);
    ticks(3);
    expect_out("R6 fall sets", SEL_REQ, 16'h0010);
    wr_reg(3'd5, 16'h0010);
    expect_out("R6 cleared", SEL_REQ, 16'h0000);
    set_pin(4, 1'b1);
    ticks(3);
    expect_out("R6 rise sets", SEL_REQ, 16'h0010);
    wr_reg(3'd5, 16'h0010);

    // R9: enable gating on pin 5 (rising)
    wr_reg(3'd0, 16'h0400);
    wr_reg(3'd2, 16'h0000);
    set_pin(5, 1'b0);
    ticks(3);
    set_pin(5, 1'b1);
    ticks(3);
    expect_out("R9 no req disabled", SEL_REQ, 16'h0000);
    expect_reg("R9 flag latched", 3'd5, 16'h0020);
    wr_reg(3'd2, 16'h0020);
    expect_out("R9 enable raises", SEL_REQ, 16'h0020);
    wr_reg(3'd5, 16'h0020);

    // R10: output pin 6
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd2, 16'h0040);
    wr_reg(3'd1, 16'h0040);
    wr_reg(3'd3, 16'h005A);
    expect_out("R10 oe", SEL_OE, 16'h0040);
    expect_out("R10 out", SEL_OUT, 16'h005A);
    set_pin(6, 1'b0);
    ticks(3);
    expect_out("R10 no req as output", SEL_REQ, 16'h0000);
    expect_reg("R10 no flag as output", 3'd5, 16'h0000);
    wr_reg(3'd1, 16'h0000);
    expect_out("R10 input again", SEL_REQ, 16'h0040);
    set_pin(6, 1'b1);
    ticks(2);
    wr_reg(3'd0, 16'h1000);
    wr_reg(3'd1, 16'h0040);
    set_pin(6, 1'b0);
    ticks(3);
    set_pin(6, 1'b1);
    ticks(3);
    wr_reg(3'd1, 16'h0000);
    expect_out("R10 no edge latched", SEL_REQ, 16'h0000);

    // R11: reserved pin 0
    wr_reg(3'd0, 16'h0000);
    wr_reg(3'd2, 16'h0001);
    set_pin(0, 1'b0);
    ticks(3);
    expect_out("R11 level", SEL_REQ, 16'h0000);
    expect_reg("R11 flag level", 3'd5, 16'h0000);
    wr_reg(3'd0, 16'h0003);
    set_pin(0, 1'b1);
    ticks(3);
    expect_out("R11 edge", SEL_REQ, 16'h0000);
    expect_reg("R11 flag edge", 3'd5, 16'h0000);

    // R2: field position of pin 7
    wr_reg(3'd0, 16'h4000);
    expect_reg("R2 readback", 3'd0, 16'h4000);
    wr_reg(3'd2, 16'h0080);
    set_pin(7, 1'b0);
    ticks(3);
    expect_out("R2 pin7 fall ignored", SEL_REQ, 16'h0000);
    set_pin(7, 1'b1);
    ticks(3);
    expect_out("R2 pin7 rise", SEL_REQ, 16'h0080);

    done = 1'b1;
    ticks(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule